// File: doc/BRIEF.md
# Tiled Layout Transfer Address Generator

This block produces the burst addresses that move an n×n complex data set between external memory and a local stripe buffer during a two-pass row-column 2D FFT. The data set is stored in a tiled layout: the matrix is cut into k×k tiles, and each tile occupies one contiguous run of physical addresses. The tile size is chosen to match one external-memory block, so every burst the block issues covers exactly one tile. No access ever strides across elements.

A `start` pulse launches one sweep over one stripe. The sweep direction is read or write. In the row pass a stripe is one tile row of n/k tiles. In the column pass it is one tile column. The controller keeps its own stripe counter. The stripe advances after its write sweep, which reissues the tiles in the same order as the read. A fence keeps the column pass from starting until every row-pass write has been accepted.

The parameters n and k arrive as base-2 logarithms. A separate combinational port translates a logical element (row, column) to its physical byte address.

Top module: `tile_burst_agen`

States and transitions:
- `ST_IDLE` goes to `ST_ISSUE` on an accepted start, or to `ST_FAULT` on a start with a bad configuration.
- `ST_ISSUE` returns to `ST_IDLE` when the last tile of the sweep is accepted.
- `ST_FAULT` goes to `ST_ISSUE` on an accepted start.

## Requirements
- R1: While `rst_n` is low and after its release, `addr_valid`, `stripe_done`, `pass_done` and `cfg_err` are 0, and the stripe counter and fence start at row pass, stripe 0.
- R2: In a row-pass sweep (`pass_col`=0) of stripe s, with t = n/k, the j-th burst (j = 0..t-1) has `tile_base` = (s·t + j)·k²·8, `burst_len` = k², and `stripe_idx` = s.
- R3: In a column-pass sweep (`pass_col`=1) of stripe s, the j-th burst has `tile_base` = (j·t + s)·k²·8, `burst_len` = k², and `stripe_idx` = s.
- R4: A write sweep (`dir_wr`=1) issues the same tiles in the same order as the read sweep of that stripe. Exactly one cycle after its last burst is accepted, `stripe_done` pulses high for one cycle, and the stripe counter advances.
- R5: On the write sweep of the last stripe, `pass_done` pulses in the same cycle as `stripe_done`, and the stripe counter returns to 0.
- R6: A column-pass start is ignored until the row pass is done. A row-pass start is ignored after the row pass is done, until the column pass is done.
- R7: While `addr_valid` is high and `addr_ready` is low, `tile_base`, `burst_len` and `stripe_idx` hold. A `start` during a sweep is ignored.
- R8: A start with `log2_k` > `log2_n`, or with `log2_n` > MAX_LOG2_N, issues no burst and raises `cfg_err`. `cfg_err` holds until a valid start is accepted.
- R9: `xl_addr` = (((r>>lk)·t + (c>>lk))·k² + (r mod k)·k + (c mod k))·8, where r = `xl_row` and c = `xl_col`, using the live `log2_n` and `log2_k`.
- R10: When k = n, each pass has one stripe of one tile at base 0, and every write sweep raises both `stripe_done` and `pass_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one stripe sweep |
| pass_col | input | 1 | 0 = row pass, 1 = column pass |
| dir_wr | input | 1 | 0 = read sweep, 1 = write-back sweep |
| log2_n | input | LOG_W | log2 of the matrix side n |
| log2_k | input | LOG_W | log2 of the tile side k |
| addr_ready | input | 1 | Memory side accepts the burst |
| addr_valid | output | 1 | A burst address is offered |
| tile_base | output | ADDR_W | Byte address of the tile |
| burst_len | output | LEN_W | Burst length in elements (k²) |
| stripe_idx | output | MAX_LOG2_N | Current stripe index |
| stripe_done | output | 1 | One-cycle pulse after a stripe's write sweep |
| pass_done | output | 1 | One-cycle pulse after the last stripe of a pass |
| cfg_err | output | 1 | Rejected configuration |
| xl_row | input | MAX_LOG2_N | Logical row to translate |
| xl_col | input | MAX_LOG2_N | Logical column to translate |
| xl_addr | output | ADDR_W | Physical byte address of (xl_row, xl_col) |

## Verification
The write sweep of the final stripe completes a stripe and a pass in the same cycle, so `stripe_done` and `pass_done` must rise together. The bench reaches this on the last write of each pass for several values of t, including the single-tile case. It checks both pulses at the one sample after the final acceptance and checks that both are gone one cycle later.

A second coincidence is a `start` landing while a burst is stalled. The bench raises `start` with the opposite pass during a ready-low cycle. It then requires the held address to be unchanged and the sweep to continue exactly as modelled.

// File: rtl/tba_pkg.sv
package tba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } agen_state_e;
endpackage

// File: rtl/tba_tile_base.sv
// Tile coordinates to tile byte base and burst length.
module tba_tile_base #(
    parameter int MAXL   = 10,
    parameter int LOG_W  = 4,
    parameter int EB     = 3,
    localparam int ADDR_W = 2*MAXL + EB,
    localparam int LEN_W  = 2*MAXL + 1
) (
    input  logic [MAXL-1:0]   tile_r,
    input  logic [MAXL-1:0]   tile_c,
    input  logic [LOG_W-1:0]  lt,
    input  logic [LOG_W-1:0]  lk,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  blen
);
    logic [2*MAXL-1:0] idx;
    logic [2*MAXL-1:0] elem;

    always_comb begin
        idx  = ({{MAXL{1'b0}}, tile_r} << lt) | {{MAXL{1'b0}}, tile_c};
        elem = idx << {lk, 1'b0};
        base = ADDR_W'(elem) << EB;
        blen = LEN_W'(1) << {lk, 1'b0};
    end
endmodule

// File: rtl/tba_elem_xlate.sv
// Logical (row, col) to physical byte address in the tiled layout.
module tba_elem_xlate #(
    parameter int MAXL   = 10,
    parameter int LOG_W  = 4,
    parameter int EB     = 3,
    localparam int ADDR_W = 2*MAXL + EB
) (
    input  logic [MAXL-1:0]   r,
    input  logic [MAXL-1:0]   c,
    input  logic [LOG_W-1:0]  ln,
    input  logic [LOG_W-1:0]  lk,
    output logic [ADDR_W-1:0] phys
);
    logic [MAXL-1:0]   kmask;
    logic [LOG_W-1:0]  lt;
    logic [2*MAXL-1:0] tile_idx;
    logic [2*MAXL-1:0] inner;
    logic [2*MAXL-1:0] elem;

    always_comb begin
        lt       = ln - lk;
        kmask    = (MAXL'(1) << lk) - MAXL'(1);
        tile_idx = ({{MAXL{1'b0}}, (r >> lk)} << lt) | {{MAXL{1'b0}}, (c >> lk)};
        inner    = ({{MAXL{1'b0}}, (r & kmask)} << lk) | {{MAXL{1'b0}}, (c & kmask)};
        elem     = (tile_idx << {lk, 1'b0}) + inner;
        phys     = ADDR_W'(elem) << EB;
    end
endmodule

// File: rtl/tile_burst_agen.sv
module tile_burst_agen
    import tba_pkg::*;
#(
    parameter int MAX_LOG2_N = 10,
    parameter int LOG_W      = 4,
    parameter int ELEM_LOG2  = 3,
    localparam int ADDR_W    = 2*MAX_LOG2_N + ELEM_LOG2,
    localparam int LEN_W     = 2*MAX_LOG2_N + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  pass_col,
    input  logic                  dir_wr,
    input  logic [LOG_W-1:0]      log2_n,
    input  logic [LOG_W-1:0]      log2_k,
    input  logic                  addr_ready,
    output logic                  addr_valid,
    output logic [ADDR_W-1:0]     tile_base,
    output logic [LEN_W-1:0]      burst_len,
    output logic [MAX_LOG2_N-1:0] stripe_idx,
    output logic                  stripe_done,
    output logic                  pass_done,
    output logic                  cfg_err,
    input  logic [MAX_LOG2_N-1:0] xl_row,
    input  logic [MAX_LOG2_N-1:0] xl_col,
    output logic [ADDR_W-1:0]     xl_addr
);
    localparam int CW = MAX_LOG2_N;

    agen_state_e state_q, state_d;

    logic [LOG_W-1:0] ln_q, lk_q, lt_q;
    logic             col_q, wr_q, fence_open_q;
    logic [CW-1:0]    j_q, s_q, last_idx;
    logic [CW:0]      tiles_per_side;
    logic             stripe_done_q, pass_done_q;
    logic             cfg_bad, accept, bad_start, fire, sweep_end;
    logic [CW-1:0]    tile_r, tile_c;

    always_comb begin
        cfg_bad        = (log2_k > log2_n) || (log2_n > LOG_W'(MAX_LOG2_N));
        accept         = start && (state_q != ST_ISSUE) && !cfg_bad
                         && (pass_col == fence_open_q);
        bad_start      = start && (state_q != ST_ISSUE) && cfg_bad;
        lt_q           = ln_q - lk_q;
        tiles_per_side = (CW+1)'(1) << lt_q;
        last_idx       = CW'(tiles_per_side - (CW+1)'(1));
        fire           = (state_q == ST_ISSUE) && addr_ready;
        sweep_end      = fire && (j_q == last_idx);
        tile_r         = col_q ? j_q : s_q;
        tile_c         = col_q ? s_q : j_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bad_start)   state_d = ST_FAULT;
                else if (accept) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (sweep_end)   state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (accept)      state_d = ST_ISSUE;
            end
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sweep counters, stripe tracking, fence and done pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q          <= '0;
            lk_q          <= '0;
            col_q         <= 1'b0;
            wr_q          <= 1'b0;
            fence_open_q  <= 1'b0;
            j_q           <= '0;
            s_q           <= '0;
            stripe_done_q <= 1'b0;
            pass_done_q   <= 1'b0;
        end else begin
            stripe_done_q <= 1'b0;
            pass_done_q   <= 1'b0;
            if (accept) begin
                ln_q  <= log2_n;
                lk_q  <= log2_k;
                col_q <= pass_col;
                wr_q  <= dir_wr;
                j_q   <= '0;
            end
            if (fire) begin
                if (sweep_end) begin
                    j_q <= '0;
                    if (wr_q) begin
                        stripe_done_q <= 1'b1;
                        if (s_q == last_idx) begin
                            pass_done_q  <= 1'b1;
                            s_q          <= '0;
                            fence_open_q <= ~fence_open_q;
                        end else begin
                            s_q <= s_q + CW'(1);
                        end
                    end
                end else begin
                    j_q <= j_q + CW'(1);
                end
            end
        end
    end

    tba_tile_base #(
        .MAXL(MAX_LOG2_N), .LOG_W(LOG_W), .EB(ELEM_LOG2)
    ) u_base (
        .tile_r(tile_r), .tile_c(tile_c), .lt(lt_q), .lk(lk_q),
        .base(tile_base), .blen(burst_len)
    );

    tba_elem_xlate #(
        .MAXL(MAX_LOG2_N), .LOG_W(LOG_W), .EB(ELEM_LOG2)
    ) u_xlate (
        .r(xl_row), .c(xl_col), .ln(log2_n), .lk(log2_k), .phys(xl_addr)
    );

    // output process
    always_comb begin
        addr_valid  = (state_q == ST_ISSUE);
        cfg_err     = (state_q == ST_FAULT);
        stripe_idx  = s_q;
        stripe_done = stripe_done_q;
        pass_done   = pass_done_q;
    end
endmodule

// File: rtl/tba_chk.sv
module tba_chk #(
    parameter int ADDR_W = 23,
    parameter int LEN_W  = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_ready,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] tile_base,
    input logic [LEN_W-1:0]  burst_len,
    input logic              stripe_done,
    input logic              pass_done,
    input logic              cfg_err
);
    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(tile_base) && $stable(burst_len));
    // R5
    pass_with_stripe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> stripe_done);
    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !addr_valid && !stripe_done && !pass_done);
    // R4
    stripe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stripe_done |-> !addr_valid);
    // R4
    stripe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stripe_done |=> !stripe_done);
    // R2
    whole_tile_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> $countones(burst_len) == 1);
endmodule

bind tile_burst_agen tba_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_ready(addr_ready), .addr_valid(addr_valid),
    .tile_base(tile_base), .burst_len(burst_len), .stripe_done(stripe_done),
    .pass_done(pass_done), .cfg_err(cfg_err)
);

// File: tb/sim_tile_burst_agen.sv
module sim_tile_burst_agen;
    localparam int CLK_P  = 10;
    localparam int MAXL   = 10;
    localparam int LOG_W  = 4;
    localparam int ADDR_W = 2*MAXL + 3;
    localparam int LEN_W  = 2*MAXL + 1;
    localparam int NVEC   = 12;
    // {log2_n[11:8], log2_k[7:4], col[3], wr[2], stall[1], pad[0]}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h322, 12'h324, 12'h320, 12'h326,
        12'h328, 12'h32E, 12'h328, 12'h32C,
        12'h220, 12'h224, 12'h22A, 12'h22C
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pass_col = 1'b0, dir_wr = 1'b0;
    logic [LOG_W-1:0] log2_n = '0, log2_k = '0;
    logic addr_ready = 1'b0;
    logic addr_valid, stripe_done, pass_done, cfg_err;
    logic [ADDR_W-1:0] tile_base, xl_addr;
    logic [LEN_W-1:0] burst_len;
    logic [MAXL-1:0] stripe_idx;
    logic [MAXL-1:0] xl_row = '0, xl_col = '0;

    int n_chk = 0, n_bad = 0, s_mod = 0;

    always #(CLK_P/2) clk = ~clk;

    tile_burst_agen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pass_col(pass_col), .dir_wr(dir_wr),
        .log2_n(log2_n), .log2_k(log2_k), .addr_ready(addr_ready),
        .addr_valid(addr_valid), .tile_base(tile_base), .burst_len(burst_len),
        .stripe_idx(stripe_idx), .stripe_done(stripe_done), .pass_done(pass_done),
        .cfg_err(cfg_err), .xl_row(xl_row), .xl_col(xl_col), .xl_addr(xl_addr)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint xl_exp(input int r, input int c, input int ln, input int lk);
        int k = 1 << lk;
        int t = 1 << (ln - lk);
        return longint'((((r / k) * t + (c / k)) * k * k + (r % k) * k + (c % k)) * 8);
    endfunction

    task automatic run_sweep(input int ln, input int lk, input int col, input int wr,
                             input int stall);
        int t  = 1 << (ln - lk);
        int k2 = 1 << (2 * lk);
        string tag;
        tag = (t == 1) ? "R10" : (wr != 0) ? "R4" : (col != 0) ? "R3" : "R2";
        @(negedge clk);
        log2_n = LOG_W'(ln); log2_k = LOG_W'(lk);
        pass_col = col[0]; dir_wr = wr[0]; start = 1'b1; addr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < t; j++) begin
            int idx = (col != 0) ? (j * t + s_mod) : (s_mod * t + j);
            longint eb = longint'(idx) * k2 * 8;
            if (stall != 0 && j == 0) begin
                addr_ready = 1'b0;
                chk("R7 valid before stall", addr_valid, 1);
                start = 1'b1; pass_col = ~col[0];
                @(negedge clk);
                start = 1'b0; pass_col = col[0];
                chk("R7 base held", tile_base, eb);
                chk("R7 valid held", addr_valid, 1);
            end
            addr_ready = 1'b1;
            chk({tag, " valid"}, addr_valid, 1);
            chk({tag, " base"}, tile_base, eb);
            chk({tag, " len"}, burst_len, k2);
            chk({tag, " stripe"}, stripe_idx, s_mod);
            @(negedge clk);
        end
        addr_ready = 1'b0;
        chk({tag, " idle after sweep"}, addr_valid, 0);
        chk("R4 stripe_done", stripe_done, wr);
        chk("R5 pass_done", pass_done, (wr != 0 && s_mod == t - 1) ? 1 : 0);
        if (wr != 0) s_mod = (s_mod == t - 1) ? 0 : s_mod + 1;
        @(negedge clk);
        chk("R4 stripe_done one cycle", stripe_done, 0);
        chk("R5 pass_done one cycle", pass_done, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", addr_valid, 0);
        chk("R1 stripe_done", stripe_done, 0);
        chk("R1 pass_done", pass_done, 0);
        chk("R1 cfg_err", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", addr_valid, 0);

        // R6 column pass blocked before the row pass completes
        log2_n = 4'd3; log2_k = 4'd2; pass_col = 1'b1; dir_wr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 col start ignored", addr_valid, 0);
        @(negedge clk);
        chk("R6 col start ignored later", addr_valid, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v = VEC[i];
            run_sweep(int'(v[11:8]), int'(v[7:4]), int'(v[3]), int'(v[2]), int'(v[1]));
        end

        // R6 row pass blocked once it is complete
        run_sweep(2, 2, 0, 0, 0);
        run_sweep(2, 2, 0, 1, 0);
        @(negedge clk);
        pass_col = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 row start ignored after fence", addr_valid, 0);
        run_sweep(2, 2, 1, 0, 0);
        run_sweep(2, 2, 1, 1, 0);

        // R8 configuration rejection
        @(negedge clk);
        log2_n = 4'd2; log2_k = 4'd3; pass_col = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 cfg_err k>n", cfg_err, 1);
        chk("R8 no burst", addr_valid, 0);
        log2_n = 4'd11; log2_k = 4'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 cfg_err n too large", cfg_err, 1);
        @(negedge clk);
        chk("R8 cfg_err held", cfg_err, 1);
        chk("R8 pass_done low", pass_done, 0);
        run_sweep(3, 2, 0, 0, 0);
        chk("R8 cfg_err cleared", cfg_err, 0);

        // R9 translation
        log2_n = 4'd3; log2_k = 4'd2; xl_row = 10'd5; xl_col = 10'd6; #1;
        chk("R9 (5,6)", xl_addr, xl_exp(5, 6, 3, 2));
        xl_row = 10'd7; xl_col = 10'd7; #1;
        chk("R9 (7,7)", xl_addr, 63 * 8);
        xl_row = 10'd2; xl_col = 10'd5; #1;
        chk("R9 (2,5)", xl_addr, xl_exp(2, 5, 3, 2));
        log2_n = 4'd5; log2_k = 4'd0; xl_row = 10'd3; xl_col = 10'd9; #1;
        chk("R9 k=1", xl_addr, (3 * 32 + 9) * 8);
        log2_n = 4'd6; log2_k = 4'd3; xl_row = 10'd41; xl_col = 10'd18; #1;
        chk("R9 (41,18)", xl_addr, xl_exp(41, 18, 6, 3));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule